// File: doc/BRIEF.md
# Daisy-Chain Readout Sequencer

This block is one of eight identical sequencers on a readout card. Each copy holds two captured channel words, A and B. Each word carries an EM energy byte and a Total energy byte. All eight copies share a transmit bus. When the upstream go line rises, every copy starts a 4-bit step counter on the same transmit clock edge. Because the copies count in lockstep, each one can decide by itself, without any arbitration, when it owns the bus.

The upper three counter bits name a bus slot, and each slot belongs to one device. The device ID is remapped by two inputs, the eta sign and the slot position (normal or eccentric), so that the card follows one of four fixed orders. The counter's low bit picks which of the device's two channels is sent first. When the counter reaches its terminal value it stops there and raises a done line, which starts the next card in the chain. A copy of done, delayed by two clocks, hands the output latches over to that next card.

Top module: `dc_readout_seq`

## Requirements
- R1: While `go_i` is low, the step counter is cleared to 0 on every clock edge. The bus stays idle: `xdata_oe_o` is 0 and `xdata_o` is 0.
- R2: With `go_i` high, the counter advances by one on each rising clock edge. The first edge after `go_i` rises therefore presents step 0 at the outputs, and edge k presents step k-1.
- R3: The counter stops at its terminal value of 15 and stays there while `go_i` remains high. After step 15 has been presented, the bus stays idle.
- R4: `done_o` is high exactly while the counter holds 15, that is, from the 15th edge after `go_i` rises. It falls on the first edge at which `go_i` is sampled low.
- R5: `done_dly2_o` equals `done_o` delayed by two clock edges, in both its rising and its falling transitions.
- R6: A device drives the bus for exactly two consecutive steps: 2s and 2s+1, where s is its remapped slot. At all other steps `xdata_oe_o` is 0.
- R7: Counter bit 0 picks the channel. With positive eta (`neg_eta_i`=0) the order is A then B. With negative eta it is B then A.
- R8: Bus slot s (s = 0..7) belongs to device d, where d = s for normal positive, d = (s+2) mod 8 for eccentric positive, d = s XOR 1 for normal negative, and d = ((s+2) mod 8) XOR 1 for eccentric negative. `normal_pos_i`=1 selects normal.
- R9: The outputs are registered. The word selected at step c appears on `xdata_o`, with `xdata_oe_o` high, after the edge that moves the counter off c. The word is passed unchanged: EM byte in bits [15:8], Total byte in bits [7:0].
- R10: Whenever `xdata_oe_o` is 0, `xdata_o` is 0.
- R11: Asserting `rst_n` low clears, at once and without a clock, the counter, `done_o`, both delay stages and the output registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Upstream go; low holds the counter at 0 |
| dev_id_i | input | 3 | This device's position on the card |
| neg_eta_i | input | 1 | 1 = negative-eta order |
| normal_pos_i | input | 1 | 1 = normal slot, 0 = eccentric slot |
| chan_a_i | input | 16 | Channel A word {EM, Total} |
| chan_b_i | input | 16 | Channel B word {EM, Total} |
| xdata_o | output | 16 | Registered bus word |
| xdata_oe_o | output | 1 | Registered bus enable |
| done_o | output | 1 | Counter at terminal count |
| done_dly2_o | output | 1 | done_o delayed two clocks |

## Verification
The assertions assume two things about the inputs. First, the ID, eta and position inputs are static straps for the whole of a readout. Second, `go_i` changes only between clock edges, so each edge samples a settled level. The bench respects both: it changes the straps only while `go_i` is low, and it drives every input on the falling clock edge. Channel words are also changed only while the bus is idle, so each expected word is known before the readout starts.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  localparam int ID_W    = 3;
  localparam int CNT_W   = ID_W + 1;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int ECC_SHIFT = 2;

  typedef logic [CNT_W-1:0]  step_t;
  typedef logic [ID_W-1:0]   slot_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rdo_counter.sv
module rdo_counter
  import rdo_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  output logic [CW-1:0] step_o,
  output logic          done_o,
  output logic          done_d1_o,
  output logic          done_d2_o
);
  localparam logic [CW-1:0] TERM = {CW{1'b1}};

  logic [CW-1:0] step_q, step_d;
  logic          step_en;
  logic          d1_q, d2_q;

  // clock enable: inverse of terminal detect
  assign step_en = (step_q != TERM);

  always_comb begin
    step_d = step_q;
    if (!go_i)        step_d = '0;
    else if (step_en) step_d = step_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      d1_q   <= 1'b0;
      d2_q   <= 1'b0;
    end else begin
      step_q <= step_d;
      d1_q   <= done_o;
      d2_q   <= d1_q;
    end
  end

  assign done_o    = (step_q == TERM);
  assign step_o    = step_q;
  assign done_d1_o = d1_q;
  assign done_d2_o = d2_q;

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !go_i |=> (step_q == '0));
  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && step_q != TERM) |=> (step_q == $past(step_q) + 1'b1));
  p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && done_o) |=> (step_q == TERM));
  p_dly_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> d1_q);
  p_dly_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
    d1_q |=> d2_q);
  p_dly_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !d1_q |=> !d2_q);
endmodule

// File: rtl/rdo_slot_map.sv
module rdo_slot_map
  import rdo_pkg::*;
#(
  parameter int IW    = ID_W,
  parameter int SHIFT = ECC_SHIFT
) (
  input  logic [IW-1:0] dev_id_i,
  input  logic          neg_eta_i,
  input  logic          normal_pos_i,
  output logic [IW-1:0] my_slot_o
);
  localparam logic [IW-1:0] SHIFT_V = IW'(SHIFT);

  logic [IW-1:0] paired_id;

  // negative eta swaps the members of each device pair
  assign paired_id = neg_eta_i ? (dev_id_i ^ IW'(1)) : dev_id_i;

  // eccentric slot rotates the card order by SHIFT devices
  generate
    if (SHIFT == 0) begin : g_no_rot
      assign my_slot_o = paired_id;
    end else begin : g_rot
      assign my_slot_o = normal_pos_i ? paired_id : (paired_id - SHIFT_V);
    end
  endgenerate
endmodule

// File: rtl/rdo_out_stage.sv
module rdo_out_stage
  import rdo_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic [CW-1:0] step_i,
  input  logic [CW-2:0] my_slot_i,
  input  logic          neg_eta_i,
  input  logic [WW-1:0] chan_a_i,
  input  logic [WW-1:0] chan_b_i,
  output logic [WW-1:0] data_o,
  output logic          oe_o
);
  logic          own_slot, take_b;
  logic [WW-1:0] data_d, data_q;
  logic          oe_d, oe_q;

  assign own_slot = active_i && (step_i[CW-1:1] == my_slot_i);
  assign take_b   = step_i[0] ^ neg_eta_i;

  always_comb begin
    oe_d   = own_slot;
    data_d = '0;
    if (own_slot) data_d = take_b ? chan_b_i : chan_a_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      oe_q   <= oe_d;
    end
  end

  assign data_o = data_q;
  assign oe_o   = oe_q;

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> (data_q == '0));
  p_inactive_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> !oe_q);
endmodule

// File: rtl/dc_readout_seq.sv
module dc_readout_seq
  import rdo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ID_W-1:0]   dev_id_i,
  input  logic              neg_eta_i,
  input  logic              normal_pos_i,
  input  logic [WORD_W-1:0] chan_a_i,
  input  logic [WORD_W-1:0] chan_b_i,
  output logic [WORD_W-1:0] xdata_o,
  output logic              xdata_oe_o,
  output logic              done_o,
  output logic              done_dly2_o
);
  step_t step;
  slot_t my_slot;
  logic  done_d1;
  logic  active;

  rdo_counter #(.CW(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go_i),
    .step_o    (step),
    .done_o    (done_o),
    .done_d1_o (done_d1),
    .done_d2_o (done_dly2_o)
  );

  rdo_slot_map #(.IW(ID_W), .SHIFT(ECC_SHIFT)) u_map (
    .dev_id_i     (dev_id_i),
    .neg_eta_i    (neg_eta_i),
    .normal_pos_i (normal_pos_i),
    .my_slot_o    (my_slot)
  );

  // the last step is presented on the edge that sets done_d1; after that, idle
  assign active = go_i && !done_d1;

  rdo_out_stage #(.CW(CNT_W), .WW(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  (active),
    .step_i    (step),
    .my_slot_i (my_slot),
    .neg_eta_i (neg_eta_i),
    .chan_a_i  (chan_a_i),
    .chan_b_i  (chan_b_i),
    .data_o    (xdata_o),
    .oe_o      (xdata_oe_o)
  );

  p_handoff_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_dly2_o |-> !xdata_oe_o);
  p_go_low_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !go_i |=> (!xdata_oe_o && !done_o));
endmodule

// File: tb/tb_dc_readout_seq.sv
module tb_dc_readout_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        go_i;
  logic [2:0]  dev_id_i;
  logic        neg_eta_i;
  logic        normal_pos_i;
  logic [15:0] chan_a_i, chan_b_i;
  logic [15:0] xdata_o;
  logic        xdata_oe_o, done_o, done_dly2_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  dc_readout_seq dut (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .dev_id_i(dev_id_i),
    .neg_eta_i(neg_eta_i), .normal_pos_i(normal_pos_i),
    .chan_a_i(chan_a_i), .chan_b_i(chan_b_i), .xdata_o(xdata_o),
    .xdata_oe_o(xdata_oe_o), .done_o(done_o), .done_dly2_o(done_dly2_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // forward order: which device owns bus slot s (R8)
  function automatic int slot_owner(input int s, input bit neg, input bit normal);
    int d;
    d = normal ? s : (s + 2) % 8;
    if (neg) d = d ^ 1;
    return d;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    go_i  = 1'b0;
    #1;
    chk("R11 oe", xdata_oe_o, 0);
    chk("R11 data", xdata_o, 0);
    chk("R11 done", done_o, 0);
    chk("R11 dly2", done_dly2_o, 0);
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  // R1: with go low the bus stays idle and done stays low
  task automatic t_idle();
    go_i = 1'b0;
    dev_id_i = 3'd0; neg_eta_i = 1'b0; normal_pos_i = 1'b1;
    chan_a_i = 16'h1234; chan_b_i = 16'h5678;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R1 oe", xdata_oe_o, 0);
      chk("R1 data", xdata_o, 0);
      chk("R1 done", done_o, 0);
    end
  endtask

  // full readout for one strap setting: R2 R3 R4 R5 R6 R7 R8 R9 R10
  task automatic t_order(input int id, input bit neg, input bit normal);
    logic [15:0] a, b, exp_w;
    bit exp_oe;
    int c;
    a = 16'(16'hA100 + id * 16'h0111 + (neg ? 16'h0800 : 0) + (normal ? 0 : 16'h0008));
    b = ~a;
    @(negedge clk);
    go_i = 1'b0;
    dev_id_i = 3'(id); neg_eta_i = neg; normal_pos_i = normal;
    chan_a_i = a; chan_b_i = b;
    tick(); tick();
    go_i = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      tick();
      exp_oe = 1'b0;
      exp_w  = 16'h0;
      if (k <= 16) begin
        c = k - 1;
        if (slot_owner(c / 2, neg, normal) == id) begin
          exp_oe = 1'b1;
          exp_w  = (((c % 2) == 1) ^ neg) ? b : a;  // R7
        end
      end
      chk("R6/R8 oe", xdata_oe_o, exp_oe);
      chk("R9/R7 data", xdata_o, exp_w);
      chk("R4 done", done_o, (k >= 15));
      chk("R5 dly2", done_dly2_o, (k >= 17));
    end
    chk("R3 halted done", done_o, 1);
    // drop go: done falls at once, dly2 two edges later
    go_i = 1'b0;
    tick();
    chk("R1 done cleared", done_o, 0);
    chk("R5 dly2 held", done_dly2_o, 1);
    tick();
    chk("R5 dly2 held2", done_dly2_o, 1);
    tick();
    chk("R5 dly2 fell", done_dly2_o, 0);
    chk("R10 idle data", xdata_o, 0);
  endtask

  // R1 abort mid-readout then restart from step 0 (R2)
  task automatic t_abort();
    @(negedge clk);
    dev_id_i = 3'd0; neg_eta_i = 1'b0; normal_pos_i = 1'b1;
    chan_a_i = 16'hBEEF; chan_b_i = 16'hCAFE;
    go_i = 1'b1;
    for (int k = 0; k < 5; k++) tick();
    go_i = 1'b0;
    tick();
    chk("R1 abort oe", xdata_oe_o, 0);
    go_i = 1'b1;
    tick();
    chk("R2 restart step0 oe", xdata_oe_o, 1);
    chk("R2 restart step0 data", xdata_o, 16'hBEEF);
    tick();
    chk("R2 restart step1 data", xdata_o, 16'hCAFE);
    tick();
    chk("R6 after pair", xdata_oe_o, 0);
    go_i = 1'b0;
    tick(); tick(); tick();
  endtask

  // R11 async reset in the middle of a readout
  task automatic t_reset_mid();
    @(negedge clk);
    dev_id_i = 3'd7; neg_eta_i = 1'b0; normal_pos_i = 1'b1;
    go_i = 1'b1;
    for (int k = 0; k < 16; k++) tick();
    chk("R11 pre oe", xdata_oe_o, 1);
    #1 rst_n = 1'b0;
    #1;
    chk("R11 mid oe", xdata_oe_o, 0);
    chk("R11 mid data", xdata_o, 0);
    chk("R11 mid done", done_o, 0);
    go_i = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    chk("R11 after dly2", done_dly2_o, 0);
  endtask

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    go_i = 1'b0;
    dev_id_i = 3'd0; neg_eta_i = 1'b0; normal_pos_i = 1'b1;
    chan_a_i = 16'h0; chan_b_i = 16'h0;
    do_reset();
    t_idle();
    for (int m = 0; m < 4; m++)
      for (int id = 0; id < 8; id++)
        t_order(id, m[1], m[0]);
    t_abort();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule